// File: doc/BRIEF.md
# Two-Dimensional Cyclic DMA Address Generator

This block sequences the word addresses for one peripheral DMA channel. Software programs a start word address, a line length, a line stride and a line count. The block then hands out one word address per handshake to an external data mover. The walk covers a strided rectangle: a fixed number of words on each line, with each new line beginning one stride after the start of the line before it. When the last word has been handed out, the block raises a finish status bit and goes quiet.

Programming a line length of zero selects ring mode. In ring mode the block walks linearly through an area of stride × line-count words and then returns to the start address without stopping. The area is split into two equal halves, and a ring status bit is raised each time the walk completes a half. This suits ping-pong audio or UART buffers. A pair of run bits pauses and resumes the walk in place. Sticky write-one-to-clear status bits, an enable mask with a separate clear path, and an abort write complete the control set.

Top module: `dma2d_addr_gen`

## Requirements
- R1: With a non-zero line length L, line count field N and stride S, the handed-out addresses are start + y·S + x for y = 0..N and x = 0..L-1, in that order. One address is handed out per cycle in which req_valid and req_advance are both high.
- R2: After the last word of the last line is handed out, status bit 0 (finish) is set and req_valid is low from that cycle until a new start.
- R3: A write to select 0 (address) loads the word address. It starts a transfer from that address with cleared counters only if both run bits are set at that moment. Otherwise req_valid stays low, and setting the run bits later does not start it.
- R4: With a line length of 0 (ring mode), addresses increase by one through S·(N+1) words and then return to the start address, with req_valid still high.
- R5: In ring mode, status bit 1 (ring) is set by the handshake of the last word of each half of the area, and not earlier.
- R6: Select 5 holds the run bits at positions 0 and 16. Requests are issued only while both are set. With either one clear, req_valid is low and req_addr holds. Setting both again resumes at the held address.
- R7: Select 6 is the status register. Writing a 1 to a bit clears that bit, and writing 0 leaves it unchanged. A set bit otherwise stays set across further events.
- R8: irq is high exactly when a status bit and its enable bit are both set. Select 7 writes the enable mask. A write to select 8 clears the enable bits that are written as 1 and leaves the others unchanged.
- R9: Select 4 is the control register. Bit 4 drives req_burst (1 = bursts of four words) and bit 5 drives req_dir (1 = device to memory).
- R10: Any write to select 9 aborts the transfer. req_valid drops on the next cycle and the status bits are unchanged.
- R11: Reading select 0 returns the current word position, which is the address to be handed out next. Selects 1 to 3 read back line length, line count and stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_sel |
| req_valid | output | 1 | An address is offered to the data mover |
| req_addr | output | 30 | Offered word address |
| req_advance | input | 1 | Data mover takes the offered address |
| req_burst | output | 1 | Burst-of-four mode |
| req_dir | output | 1 | Transfer direction |
| irq | output | 1 | Masked interrupt request |

## Verification
A table of rectangles covers four cases: a single line, lines separated by a gap, one-word lines with a wide stride, and lines packed with no gap. Together they separate a stride error, a line-count off-by-one and a line-length off-by-one, because each of these moves the final address differently. Ring mode uses an eight-word area, which shows whether the half mark fires one word early or late and whether the wrap lands on the start address. Directed steps then check pause with only one run bit set, the start gating, abort, the enable-clear path and partial write-one-to-clear.

// File: rtl/dma2d_pkg.sv
`timescale 1ns/1ps
package dma2d_pkg;
  localparam int RUN_LO_BIT = 0;
  localparam int RUN_HI_BIT = 16;
  localparam int BURST_BIT  = 4;
  localparam int DIR_BIT    = 5;
  localparam int NST        = 2;   // status bits
  localparam int ST_FIN     = 0;
  localparam int ST_RING    = 1;

  typedef enum logic [3:0] {
    SEL_ADDR  = 4'd0,
    SEL_LLEN  = 4'd1,
    SEL_LCNT  = 4'd2,
    SEL_STRD  = 4'd3,
    SEL_CTRL  = 4'd4,
    SEL_RUN   = 4'd5,
    SEL_STAT  = 4'd6,
    SEL_IEN   = 4'd7,
    SEL_IENC  = 4'd8,
    SEL_ABORT = 4'd9
  } sel_e;
endpackage

// File: rtl/dma2d_regs.sv
`timescale 1ns/1ps
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [3:0]     sel,
  input  logic [31:0]    wdata,
  output logic [LW-1:0]  llen,
  output logic [LW-1:0]  lcnt,
  output logic [LW-1:0]  strd,
  output logic           burst,
  output logic           dir,
  output logic           run_lo,
  output logic           run_hi,
  output logic [NST-1:0] ien,
  output logic           ld,
  output logic           go,
  output logic           abort,
  output logic [NST-1:0] st_clr,
  output logic [AW-1:0]  ld_addr
);
  logic [LW-1:0]  llen_n, lcnt_n, strd_n;
  logic           burst_n, dir_n, run_lo_n, run_hi_n;
  logic [NST-1:0] ien_n;
  logic           upd;
  logic           unused_wdata;

  assign unused_wdata = ^wdata;
  assign upd     = wr;
  assign ld      = wr && (sel == SEL_ADDR);
  assign go      = run_lo && run_hi;
  assign abort   = wr && (sel == SEL_ABORT);
  assign st_clr  = (wr && sel == SEL_STAT) ? wdata[NST-1:0] : '0;
  assign ld_addr = wdata[AW-1:0];

  always_comb begin
    llen_n   = llen;
    lcnt_n   = lcnt;
    strd_n   = strd;
    burst_n  = burst;
    dir_n    = dir;
    run_lo_n = run_lo;
    run_hi_n = run_hi;
    ien_n    = ien;
    case (sel)
      SEL_LLEN: llen_n = wdata[LW-1:0];
      SEL_LCNT: lcnt_n = wdata[LW-1:0];
      SEL_STRD: strd_n = wdata[LW-1:0];
      SEL_CTRL: begin
        burst_n = wdata[BURST_BIT];
        dir_n   = wdata[DIR_BIT];
      end
      SEL_RUN: begin
        run_lo_n = wdata[RUN_LO_BIT];
        run_hi_n = wdata[RUN_HI_BIT];
      end
      SEL_IEN:  ien_n = wdata[NST-1:0];
      SEL_IENC: ien_n = ien & ~wdata[NST-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llen   <= '0;
      lcnt   <= '0;
      strd   <= '0;
      burst  <= 1'b0;
      dir    <= 1'b0;
      run_lo <= 1'b0;
      run_hi <= 1'b0;
      ien    <= '0;
    end else if (upd) begin
      llen   <= llen_n;
      lcnt   <= lcnt_n;
      strd   <= strd_n;
      burst  <= burst_n;
      dir    <= dir_n;
      run_lo <= run_lo_n;
      run_hi <= run_hi_n;
      ien    <= ien_n;
    end
  end
endmodule

// File: rtl/dma2d_walker.sv
`timescale 1ns/1ps
module dma2d_walker #(
  parameter int AW = 30,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] llen,
  input  logic [LW-1:0] lcnt,
  input  logic [LW-1:0] strd,
  input  logic          go,
  input  logic          ld,
  input  logic          abort,
  input  logic [AW-1:0] ld_addr,
  input  logic          advance,
  output logic          req_valid,
  output logic [AW-1:0] cur,
  output logic          fin_evt,
  output logic          ring_evt
);
  localparam int CW = 2*LW + 1;

  logic          act, act_n;
  logic [AW-1:0] cur_n, base, base_n, ls, ls_n;
  logic [LW-1:0] xc, xc_n, yc, yc_n;
  logic [CW-1:0] ofs, ofs_n, ofs_inc, area, half;
  logic          ring, step, upd;

  assign ring      = (llen == '0);
  assign area      = CW'(strd) * (CW'(lcnt) + CW'(1));
  assign half      = area >> 1;
  assign req_valid = act && go;
  assign step      = req_valid && advance;
  assign ofs_inc   = ofs + CW'(1);
  assign upd       = ld || abort || step;

  always_comb begin
    act_n    = act;
    cur_n    = cur;
    base_n   = base;
    ls_n     = ls;
    xc_n     = xc;
    yc_n     = yc;
    ofs_n    = ofs;
    fin_evt  = 1'b0;
    ring_evt = 1'b0;
    if (abort) begin
      act_n = 1'b0;
    end else if (ld) begin
      act_n  = go;
      cur_n  = ld_addr;
      base_n = ld_addr;
      ls_n   = ld_addr;
      xc_n   = '0;
      yc_n   = '0;
      ofs_n  = '0;
    end else if (step) begin
      if (ring) begin
        if (ofs_inc == half) ring_evt = 1'b1;
        if (ofs_inc >= area) begin
          ring_evt = 1'b1;
          ofs_n    = '0;
          cur_n    = base;
        end else begin
          ofs_n = ofs_inc;
          cur_n = cur + AW'(1);
        end
      end else if (xc == llen - LW'(1)) begin
        if (yc == lcnt) begin
          act_n   = 1'b0;
          fin_evt = 1'b1;
        end else begin
          yc_n  = yc + LW'(1);
          xc_n  = '0;
          ls_n  = ls + AW'(strd);
          cur_n = ls + AW'(strd);
        end
      end else begin
        xc_n  = xc + LW'(1);
        cur_n = cur + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      cur  <= '0;
      base <= '0;
      ls   <= '0;
      xc   <= '0;
      yc   <= '0;
      ofs  <= '0;
    end else if (upd) begin
      act  <= act_n;
      cur  <= cur_n;
      base <= base_n;
      ls   <= ls_n;
      xc   <= xc_n;
      yc   <= yc_n;
      ofs  <= ofs_n;
    end
  end
endmodule

// File: rtl/dma2d_irq.sv
`timescale 1ns/1ps
module dma2d_irq
  import dma2d_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NST-1:0] st_set,
  input  logic [NST-1:0] st_clr,
  input  logic [NST-1:0] ien,
  output logic [NST-1:0] status,
  output logic           irq
);
  logic [NST-1:0] status_n;
  logic           upd;

  assign upd      = |st_set || |st_clr;
  assign status_n = (status & ~st_clr) | st_set;
  assign irq      = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= '0;
    else if (upd) status <= status_n;
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
`timescale 1ns/1ps
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_advance,
  output logic          req_burst,
  output logic          req_dir,
  output logic          irq
);
  logic           rs_q1, rs_q2;
  logic [LW-1:0]  llen, lcnt, strd;
  logic           run_lo, run_hi, go, ld, abort;
  logic [NST-1:0] ien, st_clr, status;
  logic [AW-1:0]  ld_addr;
  logic           fin_evt, ring_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  dma2d_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rs_q2), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .llen(llen), .lcnt(lcnt), .strd(strd), .burst(req_burst), .dir(req_dir),
    .run_lo(run_lo), .run_hi(run_hi), .ien(ien), .ld(ld), .go(go),
    .abort(abort), .st_clr(st_clr), .ld_addr(ld_addr)
  );

  dma2d_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rs_q2), .llen(llen), .lcnt(lcnt), .strd(strd),
    .go(go), .ld(ld), .abort(abort), .ld_addr(ld_addr),
    .advance(req_advance), .req_valid(req_valid), .cur(req_addr),
    .fin_evt(fin_evt), .ring_evt(ring_evt)
  );

  dma2d_irq u_irq (
    .clk(clk), .rst_n(rs_q2), .st_set({ring_evt, fin_evt}),
    .st_clr(st_clr), .ien(ien), .status(status), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata = 32'(req_addr);
      SEL_LLEN: reg_rdata = 32'(llen);
      SEL_LCNT: reg_rdata = 32'(lcnt);
      SEL_STRD: reg_rdata = 32'(strd);
      SEL_CTRL: begin
        reg_rdata[BURST_BIT] = req_burst;
        reg_rdata[DIR_BIT]   = req_dir;
      end
      SEL_RUN: begin
        reg_rdata[RUN_LO_BIT] = run_lo;
        reg_rdata[RUN_HI_BIT] = run_hi;
      end
      SEL_STAT: reg_rdata = 32'(status);
      SEL_IEN:  reg_rdata = 32'(ien);
      default: ;
    endcase
  end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
`timescale 1ns/1ps
module dma2d_addr_gen_chk
  import dma2d_pkg::*;
#(
  parameter int AW = 30
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [3:0]     reg_sel,
  input logic           req_valid,
  input logic [AW-1:0]  req_addr,
  input logic           go,
  input logic [NST-1:0] status,
  input logic [NST-1:0] ien,
  input logic           irq
);
  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_FIN]) |-> !req_valid); // R2

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !(reg_wr && reg_sel == SEL_ADDR)) |=> $stable(req_addr)); // R6

  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_RING] && !(reg_wr && reg_sel == SEL_STAT)) |=> status[ST_RING]); // R7

  AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_ABORT) |=> !req_valid); // R10
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .req_valid(req_valid), .req_addr(req_addr), .go(go),
  .status(status), .ien(ien), .irq(irq)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [29:0] req_addr;
  logic        req_advance;
  logic        req_burst, req_dir, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_advance(req_advance), .req_burst(req_burst),
    .req_dir(req_dir), .irq(irq)
  );

  // line length, line count field, stride, start, expected last address
  localparam logic [79:0] VEC [4] = '{
    {16'd4, 16'd0, 16'd4, 16'h0100, 16'h0103},
    {16'd3, 16'd2, 16'd8, 16'h0200, 16'h0212},
    {16'd1, 16'd3, 16'd5, 16'h0040, 16'h004F},
    {16'd5, 16'd1, 16'd5, 16'h0010, 16'h0019}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse();
    req_advance = 1'b1;
    @(negedge clk);
    req_advance = 1'b0;
  endtask

  task automatic step(input string req, input logic [31:0] exp);
    chk(req, 32'(req_valid), 1);
    chk(req, 32'(req_addr), exp);
    pulse();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0; req_advance = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R2 reset valid", 32'(req_valid), 0);
    chk("R8 reset irq", 32'(irq), 0);
    rd(4'd6, r); chk("R7 reset status", r, 0);

    // table of rectangles
    wr(4'd7, 32'h1);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] ll, lc, sd, st, la;
      logic [31:0] last;
      {ll, lc, sd, st, la} = VEC[i];
      wr(4'd1, 32'(ll)); wr(4'd2, 32'(lc)); wr(4'd3, 32'(sd));
      wr(4'd6, 32'h3);
      wr(4'd5, 32'h10001);
      wr(4'd0, 32'(st));
      rd(4'd0, r); chk("R11 position readback", r, 32'(st));
      rd(4'd3, r); chk("R11 stride readback", r, 32'(sd));
      last = 0;
      for (int y = 0; y <= int'(lc); y++)
        for (int x = 0; x < int'(ll); x++) begin
          last = 32'(st) + 32'(y) * 32'(sd) + 32'(x);
          step("R1 address", last);
        end
      chk("R1 last address", last, 32'(la));
      chk("R2 valid after finish", 32'(req_valid), 0);
      rd(4'd6, r); chk("R2 finish status", r, 32'h1);
      chk("R8 irq on finish", 32'(irq), 1);
      pulse();
      chk("R2 quiet after finish", 32'(req_valid), 0);
    end

    // ring mode: 8 word area, halves of 4
    wr(4'd7, 32'h0);
    wr(4'd1, 32'h0); wr(4'd2, 32'h1); wr(4'd3, 32'h4);
    wr(4'd6, 32'h3);
    wr(4'd0, 32'h300);
    for (int k = 0; k < 3; k++) step("R4 ring address", 32'h300 + 32'(k));
    rd(4'd6, r); chk("R5 no ring flag before half", r, 0);
    step("R4 ring address", 32'h303);
    rd(4'd6, r); chk("R5 ring flag at first half", r, 32'h2);
    wr(4'd6, 32'h1);
    rd(4'd6, r); chk("R7 writing zero keeps bit", r, 32'h2);
    wr(4'd6, 32'h2);
    rd(4'd6, r); chk("R7 write one clears", r, 0);
    for (int k = 4; k < 7; k++) step("R4 ring address", 32'h300 + 32'(k));
    rd(4'd6, r); chk("R5 no flag inside second half", r, 0);
    step("R4 ring address", 32'h307);
    rd(4'd6, r); chk("R5 ring flag at second half", r, 32'h2);
    chk("R4 still running after wrap", 32'(req_valid), 1);
    chk("R4 wrap to start", 32'(req_addr), 32'h300);
    for (int k = 0; k < 4; k++) step("R7 sticky walk", 32'h300 + 32'(k));
    rd(4'd6, r); chk("R7 sticky ring flag", r, 32'h2);

    // pause with only one run bit, then resume
    wr(4'd5, 32'h1);
    chk("R6 paused valid", 32'(req_valid), 0);
    pulse(); pulse(); pulse();
    chk("R6 paused address holds", 32'(req_addr), 32'h304);
    wr(4'd5, 32'h10000);
    chk("R6 high bit alone", 32'(req_valid), 0);
    wr(4'd5, 32'h10001);
    step("R6 resume address", 32'h304);
    chk("R6 resumed advance", 32'(req_addr), 32'h305);

    // interrupt enable and enable-clear
    wr(4'd7, 32'h3);
    chk("R8 irq ring enabled", 32'(irq), 1);
    wr(4'd8, 32'h2);
    rd(4'd7, r); chk("R8 enable clear", r, 32'h1);
    chk("R8 irq masked", 32'(irq), 0);

    // abort
    wr(4'd9, 32'h0);
    chk("R10 abort idle", 32'(req_valid), 0);
    rd(4'd6, r); chk("R10 status kept", r, 32'h2);

    // control bits
    wr(4'd4, 32'h30);
    chk("R9 burst", 32'(req_burst), 1);
    chk("R9 dir", 32'(req_dir), 1);
    wr(4'd4, 32'h10);
    chk("R9 dir clear", 32'(req_dir), 0);
    rd(4'd4, r); chk("R9 ctrl readback", r, 32'h10);

    // start gating
    wr(4'd1, 32'h2);
    wr(4'd5, 32'h0);
    wr(4'd0, 32'h55);
    chk("R3 no start without run", 32'(req_valid), 0);
    rd(4'd0, r); chk("R11 loaded address", r, 32'h55);
    wr(4'd5, 32'h10001);
    chk("R3 run alone does not start", 32'(req_valid), 0);
    wr(4'd0, 32'h60);
    step("R3 start address", 32'h60);
    chk("R3 next address", 32'(req_addr), 32'h61);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule